// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Unit

This unit sits between a processor core and a group of N peripheral devices that share one maskable interrupt request line. It merges the device requests into a single request to the core, qualifies that request with an enable flag controlled by enable and disable pulses, and holds a separate nonmaskable request that is captured on a rising edge.

When the core answers with an acknowledge pulse, the unit passes the acknowledge along the devices in position order. Device 0 sits at the head of the chain and has the highest priority. A device that is not requesting passes the acknowledge on. The first requesting device absorbs it, receives a grant, and its 8-bit vector appears on the vector output in the same cycle.

A pending nonmaskable request takes precedence over the chain. While it is pending, an acknowledge services it and no device is granted. Taking a maskable interrupt clears the enable flag, so the core must issue a fresh enable pulse before it can be interrupted again.

Top module: `irq_chain_ack`

## Requirements
- R1: After reset the enable flag is clear, no nonmaskable request is pending, all grants are 0 and the vector is 0. `irq_out` is 1 exactly when the enable flag is set and at least one bit of `dev_req` is 1.
- R2: An `ei_pulse` sets the enable flag from the next cycle. A `di_pulse` clears it from the next cycle. When both arrive in the same cycle, the disable wins.
- R3: While the enable flag is clear, an acknowledge grants no device and leaves `vec_out` at 0, whatever the device requests are.
- R4: On an acknowledge with the flag set and no nonmaskable request pending, the grant goes in that same cycle to the lowest-numbered requesting device. Bit i of `dev_grant` belongs to device i.
- R5: Devices that are not requesting pass the acknowledge on, and devices after the one that absorbs it get nothing. At most one grant bit is 1 at any time, and none is 1 if no device requests.
- R6: `vec_out` equals bits [8i+7:8i] of the `VECTORS` parameter while device i is granted, and 0 when no device is granted. By default device i has vector 0x40 + 4·i.
- R7: A cycle in which a device is granted clears the enable flag. This holds even if `ei_pulse` is 1 in that cycle, so `irq_out` is 0 in the following cycle.
- R8: A 0-to-1 transition of `nmi_in` sets `nmi_pend` in the next cycle. The flag stays set until an acknowledge. Holding `nmi_in` high does not set it again.
- R9: An acknowledge while `nmi_pend` is 1 services the nonmaskable request. No device is granted, `vec_out` is 0, `nmi_pend` clears in the next cycle, and the enable flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N | Interrupt requests, bit 0 highest priority |
| nmi_in | input | 1 | Nonmaskable request, edge-sensitive |
| ei_pulse | input | 1 | Set the enable flag |
| di_pulse | input | 1 | Clear the enable flag |
| ack_in | input | 1 | Interrupt acknowledge from the core |
| irq_out | output | 1 | Maskable request to the core |
| nmi_pend | output | 1 | Nonmaskable request pending |
| dev_grant | output | N | Acknowledge delivered to each device |
| vec_out | output | 8 | Vector of the granted device, or 0 |

## Verification
The assertions check on every cycle that:
- at most one grant is active;
- any grant goes to a requesting device with no requesting device ahead of it;
- no grant appears without an acknowledge, a set enable flag and no pending nonmaskable request;
- the vector is 0 whenever nothing is granted;
- a grant or a disable pulse removes the request in the next cycle.

Only the bench's scenarios show the rest:
- the exact vector value for each device;
- edge detection on the nonmaskable input, where a held level does not re-arm it;
- the enable flag surviving a nonmaskable acknowledge.

// File: rtl/irq_chain_ack.sv
module irq_chain_ack #(
  parameter int N = 4,
  parameter logic [N*8-1:0] VECTORS = 32'h4C48_4440
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dev_req,
  input  logic         nmi_in,
  input  logic         ei_pulse,
  input  logic         di_pulse,
  input  logic         ack_in,
  output logic         irq_out,
  output logic         nmi_pend,
  output logic [N-1:0] dev_grant,
  output logic [7:0]   vec_out
);

  logic en;
  logic nmi_q;
  logic taken;

  assign irq_out = en & (|dev_req);
  assign taken   = |dev_grant;

  always_comb begin
    logic carry;
    carry     = ack_in & en & ~nmi_pend;
    dev_grant = '0;
    vec_out   = '0;
    for (int i = 0; i < N; i++) begin
      dev_grant[i] = carry & dev_req[i];
      if (dev_grant[i]) vec_out = VECTORS[8*i +: 8];
      carry = carry & ~dev_req[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_in & ~nmi_q) | (nmi_pend & ~ack_in);
      if (di_pulse || taken) en <= 1'b0;
      else if (ei_pulse)     en <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_chain_ack_chk.sv
module irq_chain_ack_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dev_req,
  input logic         nmi_in,
  input logic         di_pulse,
  input logic         ack_in,
  input logic         irq_out,
  input logic         nmi_pend,
  input logic [N-1:0] dev_grant,
  input logic [7:0]   vec_out
);

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));

  assert_grant_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |-> (ack_in && irq_out && !nmi_pend));

  for (genvar i = 0; i < N; i++) begin : g_prio
    localparam logic [N-1:0] AHEAD = N'((1 << i) - 1);
    assert_grant_first_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dev_grant[i] |-> (dev_req[i] && ((dev_req & AHEAD) == '0)));
  end

  assert_vec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant == '0) |-> (vec_out == 8'd0));

  assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |=> !irq_out);

  assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    di_pulse |=> !irq_out);

  assert_nmi_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && nmi_pend && !nmi_in) |=> !nmi_pend);

  assert_nmi_blocks_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && nmi_pend) |-> (dev_grant == '0));

endmodule

bind irq_chain_ack irq_chain_ack_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_in(nmi_in),
  .di_pulse(di_pulse), .ack_in(ack_in), .irq_out(irq_out),
  .nmi_pend(nmi_pend), .dev_grant(dev_grant), .vec_out(vec_out)
);

// File: tb/test_irq_chain_ack.sv
module test_irq_chain_ack;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] dev_req = 0;
  logic       nmi_in = 0, ei_pulse = 0, di_pulse = 0, ack_in = 0;
  logic       irq_out, nmi_pend;
  logic [3:0] dev_grant;
  logic [7:0] vec_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_chain_ack i_irq_chain_ack (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_in(nmi_in),
    .ei_pulse(ei_pulse), .di_pulse(di_pulse), .ack_in(ack_in),
    .irq_out(irq_out), .nmi_pend(nmi_pend), .dev_grant(dev_grant),
    .vec_out(vec_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_ei();
    ei_pulse = 1; step(); ei_pulse = 0;
  endtask

  function automatic logic [3:0] lowest(logic [3:0] p);
    return p & (~p + 4'd1);
  endfunction

  function automatic logic [7:0] vec_of(logic [3:0] g);
    for (int i = 0; i < 4; i++) if (g[i]) return 8'(64 + 4 * i);
    return 8'd0;
  endfunction

  initial begin
    step(); step();
    chk("R1 reset irq", {31'd0, irq_out}, 0);
    chk("R1 reset pend", {31'd0, nmi_pend}, 0);
    chk("R1 reset grant", {28'd0, dev_grant}, 0);
    chk("R1 reset vec", {24'd0, vec_out}, 0);
    rst_n = 1; step();

    // R4 R5 R6 R7: sweep every request pattern with enable set
    for (int p = 0; p < 16; p++) begin
      pulse_ei();
      dev_req = 4'(p);
      #1;
      chk("R1 irq", {31'd0, irq_out}, {31'd0, p != 0});
      ack_in = 1; #1;
      chk("R4 R5 grant", {28'd0, dev_grant}, {28'd0, lowest(4'(p))});
      chk("R6 vec", {24'd0, vec_out}, {24'd0, vec_of(lowest(4'(p)))});
      ei_pulse = (p == 5);
      step(); ack_in = 0; ei_pulse = 0; #1;
      if (p != 0) chk("R7 enable cleared", {31'd0, irq_out}, 0);
      else chk("R7 enable kept", {31'd0, irq_out}, 0);
    end
    dev_req = 4'hF; #1;
    chk("R7 still masked", {31'd0, irq_out}, 0);

    // R3: disabled, acknowledge ignored for every pattern
    pulse_ei(); di_pulse = 1; step(); di_pulse = 0;
    for (int p = 0; p < 16; p++) begin
      dev_req = 4'(p); ack_in = 1; #1;
      chk("R3 irq", {31'd0, irq_out}, 0);
      chk("R3 grant", {28'd0, dev_grant}, 0);
      chk("R3 vec", {24'd0, vec_out}, 0);
      step(); ack_in = 0;
    end

    // R2: simultaneous EI and DI, disable wins
    dev_req = 4'b0100;
    ei_pulse = 1; di_pulse = 1; step(); ei_pulse = 0; di_pulse = 0; #1;
    chk("R2 di wins", {31'd0, irq_out}, 0);
    pulse_ei(); #1;
    chk("R2 ei sets", {31'd0, irq_out}, 1);
    step(); #1;
    chk("R2 enable holds", {31'd0, irq_out}, 1);

    // R8 R9: nonmaskable edge, precedence, enable preserved
    nmi_in = 1; #1;
    chk("R8 not yet pending", {31'd0, nmi_pend}, 0);
    step(); #1;
    chk("R8 pending", {31'd0, nmi_pend}, 1);
    step(); step(); #1;
    chk("R8 held", {31'd0, nmi_pend}, 1);
    ack_in = 1; #1;
    chk("R9 no grant", {28'd0, dev_grant}, 0);
    chk("R9 vec zero", {24'd0, vec_out}, 0);
    step(); ack_in = 0; #1;
    chk("R9 pend cleared", {31'd0, nmi_pend}, 0);
    chk("R9 enable kept", {31'd0, irq_out}, 1);
    step(); step(); #1;
    chk("R8 level no retrigger", {31'd0, nmi_pend}, 0);
    ack_in = 1; #1;
    chk("R9 chain after nmi", {28'd0, dev_grant}, 4'b0100);
    chk("R6 vec dev2", {24'd0, vec_out}, 8'h48);
    step(); ack_in = 0;
    nmi_in = 0; step(); nmi_in = 1; step(); #1;
    chk("R8 second edge", {31'd0, nmi_pend}, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule